// File: doc/BRIEF.md
# Programmable Scan Timing Generator

This block produces the scan timing for a multiplexed keypad and digit display. A programmable divider reduces the system clock to an internal scan tick, nominally about 100 kHz. A sequencer counts those ticks and moves a 4-bit scan index forward by one once per digit period. The index wraps from 15 back to 0.

The index drives four scan lines in one of two formats. In binary format the lines carry the index itself, active high, so that a 4-to-16 decoder outside the block can fan it out. In one-cold format the two low index bits select one of four lines, which is pulled low, so that four digits or four keypad rows can be driven directly. A one-cycle strobe marks each change of digit. A qualifier shows whether the current position falls in the part of the scan that the keypad uses: the keypad reads only 8 of the 16 binary positions.

The sequencer has two states. SEQ_DWELL counts ticks while the current digit is held. SEQ_STEP lasts one cycle, shows the new index and raises the strobe. The transition SEQ_DWELL→SEQ_STEP is taken on the tick that completes the digit period. The transition SEQ_STEP→SEQ_DWELL is always taken on the next cycle.

Top module: `scan_timing_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high) the outputs are `scan_idx`=0, `scan_lines`=4'b0000, `tick`=0, `digit_strobe`=0 and `kb_row_active`=1, whatever the value of `decode_sel`.
- R2: `tick` is a one-cycle pulse once every N clock cycles. N equals `presc_val` for values 2 to 31, and N is 2 for the values 0 and 1. After reset is released, the first pulse comes in cycle N.
- R3: `scan_idx` increases by one after every TICKS_PER_DIGIT ticks, that is every TICKS_PER_DIGIT×N cycles, and wraps from 15 to 0.
- R4: `digit_strobe` is high for exactly one cycle, the first cycle in which a new `scan_idx` is visible. It is low in every other cycle.
- R5: In binary format (`decode_sel`=0), `scan_lines` equals `scan_idx`, active high.
- R6: In one-cold format (`decode_sel`=1), `scan_lines` bit i is low exactly when `scan_idx[1:0]`=i, which gives the cycle 1110, 1101, 1011, 0111.
- R7: `decode_sel` is registered. A change takes effect in the cycle after the edge that samples it, and reset forces binary format.
- R8: `kb_row_active` is high when `scan_idx` < 8 in binary format and always high in one-cold format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_val | input | 5 | Clock divide ratio for the scan tick |
| decode_sel | input | 1 | 0 = binary scan lines, 1 = one-cold scan lines |
| scan_lines | output | 4 | Scan outputs |
| scan_idx | output | 4 | Current scan position |
| tick | output | 1 | Internal scan tick pulse |
| digit_strobe | output | 1 | One-cycle pulse when the digit changes |
| kb_row_active | output | 1 | Current position belongs to the keypad scan |

## Verification
The bench builds the block with TICKS_PER_DIGIT set to 4 instead of 64. This makes a full 16-position scan short enough to run several times. With it the bench covers the index wrap, divider settings 0, 1, 5 and 31, and both output formats. All of these run within the cycle budget. Divide ratio and digit length use the same counting logic whatever their value, so the smaller digit length reaches the same corner cases as the default.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int SCAN_W    = 4;
    localparam int DEC_SEL_W = 2;
    localparam int KB_ROWS   = 8;

    typedef enum logic [0:0] {
        SEQ_DWELL = 1'b0,
        SEQ_STEP  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] presc_val,
    output logic               tick
);
    localparam logic [PRESC_W-1:0] MIN_DIV = PRESC_W'(2);

    logic [PRESC_W-1:0] pcnt;
    logic [PRESC_W-1:0] div_last;

    // Ratios below two fall back to divide-by-two.
    always_comb begin
        if (presc_val < MIN_DIV)
            div_last = MIN_DIV - PRESC_W'(1);
        else
            div_last = presc_val - PRESC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (pcnt >= div_last)
            pcnt <= '0;
        else
            pcnt <= pcnt + PRESC_W'(1);
    end

    assign tick = (pcnt == div_last);
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int TICKS_PER_DIGIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [SCAN_W-1:0] scan_cnt,
    output logic              digit_strobe
);
    localparam int TW = (TICKS_PER_DIGIT > 1) ? $clog2(TICKS_PER_DIGIT) : 1;
    localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_DIGIT - 1);

    seq_state_t        state, state_nx;
    logic [TW-1:0]     tcnt;
    logic              period_done;

    assign period_done = tick && (tcnt == TLAST);

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state <= SEQ_DWELL;
        else
            state <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_DWELL: if (period_done) state_nx = SEQ_STEP;
            SEQ_STEP:  state_nx = SEQ_DWELL;
            default:   state_nx = SEQ_DWELL;
        endcase
    end

    // Tick counter within a digit and the scan position.
    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt     <= '0;
            scan_cnt <= '0;
        end else begin
            if (tick)
                tcnt <= (tcnt == TLAST) ? '0 : tcnt + TW'(1);
            if (state == SEQ_DWELL && state_nx == SEQ_STEP)
                scan_cnt <= scan_cnt + SCAN_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        digit_strobe = (state == SEQ_STEP);
    end
endmodule

// File: rtl/scan_line_encoder.sv
module scan_line_encoder
    import scan_pkg::*;
(
    input  logic              mode_dec,
    input  logic [SCAN_W-1:0] cnt,
    output logic [SCAN_W-1:0] lines,
    output logic              kb_row_active
);
    localparam int DEC_LINES = 1 << DEC_SEL_W;

    logic [DEC_LINES-1:0] cold;

    for (genvar g = 0; g < DEC_LINES; g++) begin : g_cold
        assign cold[g] = (cnt[DEC_SEL_W-1:0] != DEC_SEL_W'(g));
    end

    always_comb begin
        lines         = mode_dec ? SCAN_W'(cold) : cnt;
        kb_row_active = mode_dec || (cnt < SCAN_W'(KB_ROWS));
    end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_pkg::*;
#(
    parameter int PRESC_W         = 5,
    parameter int TICKS_PER_DIGIT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] presc_val,
    input  logic               decode_sel,
    output logic [SCAN_W-1:0]  scan_lines,
    output logic [SCAN_W-1:0]  scan_idx,
    output logic               tick,
    output logic               digit_strobe,
    output logic               kb_row_active
);
    logic mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 1'b0;
        else
            mode_q <= decode_sel;
    end

    scan_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .presc_val (presc_val),
        .tick      (tick)
    );

    scan_sequencer #(.TICKS_PER_DIGIT(TICKS_PER_DIGIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .scan_cnt     (scan_idx),
        .digit_strobe (digit_strobe)
    );

    scan_line_encoder u_enc (
        .mode_dec      (mode_q),
        .cnt           (scan_idx),
        .lines         (scan_lines),
        .kb_row_active (kb_row_active)
    );
endmodule

// File: rtl/scan_timing_gen_chk.sv
module scan_timing_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       digit_strobe,
    input logic [3:0] scan_idx,
    input logic [3:0] scan_lines,
    input logic       kb_row_active,
    input logic       mode_q
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        digit_strobe |-> scan_idx == $past(scan_idx) + 4'd1); // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !digit_strobe |-> $stable(scan_idx)); // R4
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        digit_strobe |=> !digit_strobe); // R4
    AST_ENC_MATCH: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> scan_lines == scan_idx); // R5
    AST_DEC_ONECOLD: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> $countones(~scan_lines) == 1); // R6
    AST_KB_UPPER: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && scan_idx[3]) |-> !kb_row_active); // R8
endmodule

bind scan_timing_gen scan_timing_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .digit_strobe  (digit_strobe),
    .scan_idx      (scan_idx),
    .scan_lines    (scan_lines),
    .kb_row_active (kb_row_active),
    .mode_q        (mode_q)
);

// File: tb/scan_timing_gen_test.sv
module scan_timing_gen_test;
    localparam int TPD     = 4;
    localparam int WD_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] presc_val = 5'd2;
    logic       decode_sel = 1'b0;
    logic [3:0] scan_lines, scan_idx;
    logic       tick, digit_strobe, kb_row_active;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    scan_timing_gen #(.PRESC_W(5), .TICKS_PER_DIGIT(TPD)) uut (
        .clk           (clk),
        .rst           (rst),
        .presc_val     (presc_val),
        .decode_sel    (decode_sel),
        .scan_lines    (scan_lines),
        .scan_idx      (scan_idx),
        .tick          (tick),
        .digit_strobe  (digit_strobe),
        .kb_row_active (kb_row_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_lines(input int idx, input bit dec);
        if (dec) return ~(4'b0001 << (idx % 4));
        return 4'(idx);
    endfunction

    task automatic apply_reset(input logic [4:0] p, input bit dec);
        @(negedge clk);
        rst = 1'b1; presc_val = p; decode_sel = dec;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: values held during reset, one-cold request ignored
    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1; presc_val = 5'd7; decode_sel = 1'b1;
        repeat (3) @(negedge clk);
        check(scan_idx == 4'd0, "R1 scan_idx", scan_idx, 0);
        check(scan_lines == 4'b0000, "R1 scan_lines (R7 encoded)", scan_lines, 0);
        check(tick == 1'b0, "R1 tick", tick, 0);
        check(digit_strobe == 1'b0, "R1 digit_strobe", digit_strobe, 0);
        check(kb_row_active == 1'b1, "R1 kb_row_active", kb_row_active, 1);
    endtask

    // R2 R3 R4 R5 R6 R8: cycle by cycle over more than one full scan
    task automatic t_scan_run(input logic [4:0] p, input int n, input bit dec);
        int per, cyc, idx;
        per = TPD * n;
        cyc = 17 * per + 3;
        apply_reset(p, dec);
        for (int k = 1; k <= cyc; k++) begin
            @(negedge clk);
            idx = (k / per) % 16;
            check(tick == ((k % n) == n - 1), "R2 tick", tick, (k % n) == n - 1);
            check(scan_idx == 4'(idx), "R3 scan_idx", scan_idx, idx);
            check(digit_strobe == (k % per == 0), "R4 digit_strobe", digit_strobe, k % per == 0);
            check(scan_lines == exp_lines(idx, dec), dec ? "R6 scan_lines" : "R5 scan_lines",
                  scan_lines, exp_lines(idx, dec));
            check(kb_row_active == (dec || idx < 8), "R8 kb_row_active", kb_row_active, dec || idx < 8);
        end
    endtask

    // R7: format change lands one edge after the input changes
    task automatic t_mode_switch();
        int idx;
        apply_reset(5'd3, 1'b0);
        repeat (TPD * 3 * 2 + 1) @(negedge clk);
        idx = scan_idx;
        check(idx == 2, "R7 setup scan_idx", idx, 2);
        decode_sel = 1'b1;
        #1;
        check(scan_lines == 4'(idx), "R7 before edge", scan_lines, idx);
        @(negedge clk);
        check(scan_lines == 4'b1011, "R7 after edge decoded", scan_lines, 4'b1011);
        decode_sel = 1'b0;
        #1;
        check(scan_lines == 4'b1011, "R7 before edge back", scan_lines, 4'b1011);
        @(negedge clk);
        check(scan_lines == 4'(idx), "R7 after edge encoded", scan_lines, idx);
    endtask

    initial begin
        #(WD_CYC * 20);
        bad++;
        total++;
        $display("FAIL watchdog all actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_scan_run(5'd0, 2, 1'b0);
        t_scan_run(5'd1, 2, 1'b1);
        t_scan_run(5'd5, 5, 1'b0);
        t_scan_run(5'd31, 31, 1'b1);
        t_mode_switch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule